// File: doc/BRIEF.md
# Prescaled Bit-Rate Timing Generator

This block produces the timing strobes for one serial channel from the peripheral clock. A selectable prescaler divides the clock by 1, 8, 32 or 256. The prescaled clock steps an 8-bit down-counter. The counter reloads from a programmed value and signals an underflow once every reload+1 prescaled clocks. Each underflow is one rate tick.

The rate tick is divided again according to the channel mode. In asynchronous mode the rate tick serves as the 16x oversampling strobe, and one bit strobe is produced every 16 ticks. In synchronous mode one bit strobe is produced every 2 ticks. In asynchronous mode, an optional pin output toggles on every rate tick, which gives a fixed clock at half the tick rate.

The undivided clock combined with synchronous mode would allow bit rates above what the shift logic can follow. For that setting, reload values below 4 are raised to 4, which keeps the bit rate at or below one tenth of the clock. A new reload value is taken only at the next underflow. Dropping the enable clears all the timing state and holds every output low.

Top module: `brate_gen`

## Requirements
- R1: The prescaler select encodes 0 = divide by 1, 1 = divide by 8, 2 = divide by 32, 3 = divide by 256. With select divisor P and reload n (no clamping), `rate_tick` pulses for one cycle every (n+1)*P clock cycles.
- R2: With the divide-by-1 prescaler in asynchronous mode, every reload value from 0 to 255 gives a `rate_tick` period of n+1 cycles.
- R3: In asynchronous mode (`sync_mode` = 0), `bit_tick` pulses once every 16 `rate_tick` pulses, so its period is 16 rate-tick periods.
- R4: In synchronous mode (`sync_mode` = 1), `bit_tick` pulses once every 2 `rate_tick` pulses.
- R5: When the prescaler select is 0 and `sync_mode` = 1, a reload value below 4 acts as 4 (a `rate_tick` period of 5 cycles). The clamp is not applied with any other select, or in asynchronous mode.
- R6: A change of `reload` does not alter the count in progress. The new value sets the period starting from the next underflow.
- R7: While `enable` is low, all three outputs are low one cycle later and the counters are cleared. After `enable` rises, the first `rate_tick` appears after the P-th clock edge that samples `enable` high.
- R8: With `sync_mode` = 0 and `pin_en` = 1, `clk_pin` starts low after enable and toggles at every `rate_tick`. It changes at no other time while the configuration is held.
- R9: `clk_pin` stays low whenever `sync_mode` = 1 or `pin_en` = 0.
- R10: `bit_tick` is asserted only in a cycle in which `rate_tick` is also asserted.
- R11: During and directly after reset (`rst_n` low, active-low and asynchronous), all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator; low clears the state and holds the outputs low |
| pre_sel | input | 2 | Prescaler select: 0 /1, 1 /8, 2 /32, 3 /256 |
| reload | input | 8 | Reload value n of the down-counter |
| sync_mode | input | 1 | 0 asynchronous (divide by 16), 1 synchronous (divide by 2) |
| pin_en | input | 1 | Enables the fixed-period pin clock in asynchronous mode |
| rate_tick | output | 1 | One-cycle strobe at each counter underflow |
| bit_tick | output | 1 | One-cycle strobe per bit period |
| clk_pin | output | 1 | Pin clock at half the rate-tick frequency |

## Verification
All three outputs are registered. A decision made at a clock edge therefore appears in the same cycle as that edge, and the bench samples it at the next falling edge. An underflow that a rising edge detects shows up at the following falling edge. The bench measures periods by counting falling edges between consecutive strobes, which makes the measurement independent of the starting phase. Two tests need absolute timing: the first strobe after enable, which is due exactly P edges after enable is sampled high, and the clearing of the outputs after enable drops, which is due one edge later. For these two tests, the bench counts from the falling edge at which it changed the input.

// File: rtl/brate_pkg.sv
package brate_pkg;
    typedef enum logic [1:0] {
        PRE_DIV1   = 2'd0,
        PRE_DIV8   = 2'd1,
        PRE_DIV32  = 2'd2,
        PRE_DIV256 = 2'd3
    } pre_sel_e;

    typedef enum logic {
        MODE_ASYNC = 1'b0,
        MODE_SYNC  = 1'b1
    } chan_mode_e;
endpackage

// File: rtl/brate_prescale.sv
module brate_prescale #(
    parameter int PRE_W = 8,
    parameter int DIV_B = 8,
    parameter int DIV_C = 32,
    parameter int DIV_D = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] pre_sel,
    output logic       pre_tick
);
    import brate_pkg::*;

    localparam logic [PRE_W-1:0] LIM_A = '0;
    localparam logic [PRE_W-1:0] LIM_B = PRE_W'(DIV_B - 1);
    localparam logic [PRE_W-1:0] LIM_C = PRE_W'(DIV_C - 1);
    localparam logic [PRE_W-1:0] LIM_D = PRE_W'(DIV_D - 1);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        unique case (pre_sel_e'(pre_sel))
            PRE_DIV1:   limit = LIM_A;
            PRE_DIV8:   limit = LIM_B;
            PRE_DIV32:  limit = LIM_C;
            default:    limit = LIM_D;
        endcase
        pre_tick = enable && (st_q.cnt >= limit);
        st_d = st_q;
        if (!enable) begin
            st_d.cnt = '0;
        end else if (pre_tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/brate_reload.sv
module brate_reload #(
    parameter int CNT_W     = 8,
    parameter int CLAMP_MIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             pre_tick,
    input  logic             clamp_req,
    input  logic [CNT_W-1:0] reload,
    output logic             underflow
);
    localparam logic [CNT_W-1:0] CLAMP_V = CNT_W'(CLAMP_MIN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } rl_state_t;

    rl_state_t st_d, st_q;
    logic [CNT_W-1:0] eff_reload;

    always_comb begin
        eff_reload = (clamp_req && (reload < CLAMP_V)) ? CLAMP_V : reload;
        underflow  = enable && pre_tick && (st_q.cnt == '0);
        st_d = st_q;
        if (!enable) begin
            st_d.cnt = '0;
        end else if (pre_tick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = eff_reload;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/brate_postdiv.sv
module brate_postdiv #(
    parameter int OVS      = 16,
    parameter int SYNC_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic underflow,
    input  logic sync_mode,
    input  logic pin_en,
    output logic rate_tick,
    output logic bit_tick,
    output logic clk_pin
);
    import brate_pkg::*;

    localparam int PD_W = $clog2(OVS);
    localparam logic [PD_W-1:0] LAST_ASYNC = PD_W'(OVS - 1);
    localparam logic [PD_W-1:0] LAST_SYNC  = PD_W'(SYNC_DIV - 1);

    typedef struct packed {
        logic [PD_W-1:0] pd;
        logic            rate;
        logic            bitp;
        logic            pin;
    } pd_state_t;

    pd_state_t st_d, st_q;
    logic [PD_W-1:0] last;
    logic            pin_on;

    always_comb begin
        last   = (chan_mode_e'(sync_mode) == MODE_SYNC) ? LAST_SYNC : LAST_ASYNC;
        pin_on = (chan_mode_e'(sync_mode) == MODE_ASYNC) && pin_en;
        st_d = st_q;
        if (!enable) begin
            st_d = '0;
        end else begin
            st_d.rate = underflow;
            st_d.bitp = 1'b0;
            if (underflow) begin
                if (st_q.pd >= last) begin
                    st_d.pd   = '0;
                    st_d.bitp = 1'b1;
                end else begin
                    st_d.pd = st_q.pd + 1'b1;
                end
            end
            st_d.pin = pin_on ? (st_q.pin ^ underflow) : 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rate_tick = st_q.rate;
    assign bit_tick  = st_q.bitp;
    assign clk_pin   = st_q.pin;
endmodule

// File: rtl/brate_gen.sv
module brate_gen #(
    parameter int CNT_W     = 8,
    parameter int PRE_W     = 8,
    parameter int OVS       = 16,
    parameter int SYNC_DIV  = 2,
    parameter int CLAMP_MIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       pre_sel,
    input  logic [CNT_W-1:0] reload,
    input  logic             sync_mode,
    input  logic             pin_en,
    output logic             rate_tick,
    output logic             bit_tick,
    output logic             clk_pin
);
    import brate_pkg::*;

    logic pre_tick;
    logic underflow;
    logic clamp_req;

    assign clamp_req = (pre_sel_e'(pre_sel) == PRE_DIV1) &&
                       (chan_mode_e'(sync_mode) == MODE_SYNC);

    brate_prescale #(
        .PRE_W (PRE_W)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .pre_sel  (pre_sel),
        .pre_tick (pre_tick)
    );

    brate_reload #(
        .CNT_W     (CNT_W),
        .CLAMP_MIN (CLAMP_MIN)
    ) u_rl (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .pre_tick  (pre_tick),
        .clamp_req (clamp_req),
        .reload    (reload),
        .underflow (underflow)
    );

    brate_postdiv #(
        .OVS      (OVS),
        .SYNC_DIV (SYNC_DIV)
    ) u_pd (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .underflow (underflow),
        .sync_mode (sync_mode),
        .pin_en    (pin_en),
        .rate_tick (rate_tick),
        .bit_tick  (bit_tick),
        .clk_pin   (clk_pin)
    );
endmodule

// File: rtl/brate_gen_chk.sv
module brate_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic sync_mode,
    input logic pin_en,
    input logic rate_tick,
    input logic bit_tick,
    input logic clk_pin
);
    assert_bit_with_rate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> rate_tick);

    assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!rate_tick && !bit_tick && !clk_pin));

    assert_pin_rise_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_pin && !$past(clk_pin)) |-> rate_tick);

    assert_pin_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode || !pin_en) |=> !clk_pin);

    assert_reset_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rate_tick && !bit_tick && !clk_pin));
endmodule

bind brate_gen brate_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .sync_mode (sync_mode),
    .pin_en    (pin_en),
    .rate_tick (rate_tick),
    .bit_tick  (bit_tick),
    .clk_pin   (clk_pin)
);

// File: tb/brate_gen_tb.sv
module brate_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] pre_sel = 2'd0;
    logic [7:0] reload = 8'd0;
    logic       sync_mode = 1'b0;
    logic       pin_en = 1'b0;
    logic       rate_tick, bit_tick, clk_pin;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    brate_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .pre_sel   (pre_sel),
        .reload    (reload),
        .sync_mode (sync_mode),
        .pin_en    (pin_en),
        .rate_tick (rate_tick),
        .bit_tick  (bit_tick),
        .clk_pin   (clk_pin)
    );

    always #5 clk = ~clk;

    localparam int NV = 12;
    localparam int V_PSEL [NV] = '{0, 0, 0, 1, 2, 3, 0, 0, 0, 0, 1, 3};
    localparam int V_MODE [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1};
    localparam int V_RLD  [NV] = '{0, 9, 255, 2, 4, 1, 0, 3, 4, 7, 0, 2};
    localparam int V_RATE [NV] = '{1, 10, 256, 24, 160, 512, 5, 5, 5, 8, 8, 768};
    localparam int V_BIT  [NV] = '{16, 160, 4096, 384, 2560, 8192, 10, 10, 10, 16, 16, 1536};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse(input bit which, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(which ? bit_tick : rate_tick));
    endtask

    task automatic setcfg(input int ps, input int md, input int rl, input bit pe);
        @(negedge clk);
        enable    = 1'b0;
        pre_sel   = 2'(ps);
        sync_mode = md[0];
        reload    = 8'(rl);
        pin_en    = pe;
        @(negedge clk);
        enable    = 1'b1;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int c;
        int hi;
        string tg;
        // R11: reset state, even with enable driven high
        enable = 1'b1;
        repeat (4) @(negedge clk);
        check(!rate_tick && !bit_tick && !clk_pin, "R11",
              {rate_tick, bit_tick, clk_pin}, 0);
        enable = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rate_tick && !bit_tick && !clk_pin, "R11",
              {rate_tick, bit_tick, clk_pin}, 0);

        // Vector table: rate period (R1/R2/R5) and bit period (R3/R4/R5)
        for (int i = 0; i < NV; i++) begin
            setcfg(V_PSEL[i], V_MODE[i], V_RLD[i], 1'b0);
            wait_pulse(1'b0, c);
            wait_pulse(1'b0, c);
            tg = (i >= 6 && i <= 8) ? "R5" : ((V_PSEL[i] == 0) ? "R2" : "R1");
            check(c == V_RATE[i], tg, c, V_RATE[i]);
            wait_pulse(1'b1, c);
            check(rate_tick == 1'b1, "R10", rate_tick, 1);
            wait_pulse(1'b1, c);
            tg = (i >= 6 && i <= 8) ? "R5" : ((V_MODE[i] == 0) ? "R3" : "R4");
            check(c == V_BIT[i], tg, c, V_BIT[i]);
        end

        // R7: first tick after enable lands on the P-th enabled edge
        setcfg(1, 0, 0, 1'b0);
        wait_pulse(1'b0, c);
        check(c == 8, "R7", c, 8);
        setcfg(0, 0, 5, 1'b0);
        wait_pulse(1'b0, c);
        check(c == 1, "R7", c, 1);

        // R7: dropping enable mid-run clears outputs one edge later
        setcfg(0, 0, 0, 1'b1);
        repeat (3) @(negedge clk);
        enable = 1'b0;
        hi = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (rate_tick || bit_tick || clk_pin) hi++;
        end
        check(hi == 0, "R7", hi, 0);

        // R6: reload change applies from the next underflow
        setcfg(0, 0, 9, 1'b0);
        wait_pulse(1'b0, c);
        reload = 8'd3;
        wait_pulse(1'b0, c);
        check(c == 10, "R6", c, 10);
        wait_pulse(1'b0, c);
        check(c == 4, "R6", c, 4);

        // R8: pin toggles at each rate tick, starting low
        setcfg(0, 0, 2, 1'b1);
        check(clk_pin == 1'b0, "R8", clk_pin, 0);
        for (int k = 0; k < 4; k++) begin
            wait_pulse(1'b0, c);
            check(clk_pin == ((k % 2) == 0), "R8", clk_pin, ((k % 2) == 0));
            @(negedge clk);
            check(clk_pin == ((k % 2) == 0), "R8", clk_pin, ((k % 2) == 0));
        end

        // R9: pin quiet in sync mode and with the pin disabled
        setcfg(0, 1, 0, 1'b1);
        hi = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (clk_pin) hi++;
        end
        check(hi == 0, "R9", hi, 0);
        setcfg(0, 0, 0, 1'b0);
        hi = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (clk_pin) hi++;
        end
        check(hi == 0, "R9", hi, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule